// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Port

This block is the receive side of a programmable asynchronous serial port. It sits on a small 8-bit processor bus and turns a serial line into bytes. The bus has chip select, read and write strobes and a control/data select. The serial input is sampled with one bit period equal to `BIT_CYCLES` clocks, which is the single-rate (1X) clocking this block supports. The processor programs the framing with a mode byte and then controls the receiver with command bytes. It polls a status byte or watches the `rxrdy` pin, and then reads the receive buffer.

Bus accesses are synchronous. Each clock in which `cs_n` and `rd_n` (or `wr_n`) are low counts as one access, so a strobe lasts exactly one clock. Read data on `dout` is combinational while the read strobe is asserted. Parity, overrun and framing errors are sticky. A received character is stored even when it carries an error, and only the error-reset command bit clears the error flags.

Top module: `serrx_port`

## Requirements
- R1: The first control write (`cd`=1) after reset loads the mode byte. Status reads 0x80 after initialisation with `dsr_n` low and no character received. Status bit 7 is the inverse of `dsr_n`, and bits 0, 2 and 6 read 0.
- R2: Every later control write is a command. Command bit 2 enables the receiver. Command bit 4 clears the parity, overrun and framing flags, so 0x14 enables reception and clears the errors.
- R3: Mode 0xFD selects 8 data bits, even parity and 2 stop bits. A correct frame for 0x55 (LSB first, then the parity bit, then the stop bit) sets `rxrdy`, status reads 0x82 and the buffer reads 0x55.
- R4: `rxrdy` goes low once a start bit is confirmed at its half-bit check. It stays low during the character and rises after the first stop bit is sampled.
- R5: A parity mismatch sets status bit 3 and still raises `rxrdy`, and the data bits are stored unchanged. For 0x5A with wrong parity, status reads 0x8A and the buffer reads 0x5A.
- R6: A low stop bit sets status bit 5, raises `rxrdy` and stores the character. For 0x57, status reads 0xA2 and the buffer reads 0x57.
- R7: A buffer read (`cd`=0) clears `rxrdy` and status bit 1. A second read returns the same byte.
- R8: If a character completes while the previous one is still unread, status bit 4 (overrun) is set and the new character replaces the old one in the buffer.
- R9: Error flags remain set through later error-free characters and buffer reads until a command with bit 4 is written.
- R10: A low pulse on the serial input that is shorter than half a bit period is rejected: no character is received and `rxrdy` stays low.
- R11: While command bit 2 is clear, start bits are ignored and `rxrdy` is low.
- R12: Mode bits 3:2 select 5, 6, 7 or 8 data bits (00 to 11). Shorter characters are read right-justified with the upper bits zero. Mode bit 4 enables parity, and mode bit 5 selects even (1) or odd (0) parity.
- R13: A buffer read in the same clock as a character completes returns the old byte and leaves `rxrdy` set with no overrun. A command with bit 4 in the completing clock of a character with a parity error leaves the parity flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit period is `BIT_CYCLES` clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| cd | input | 1 | 1 = mode/command/status, 0 = data |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data: status or receive buffer, 0 when not reading |
| rxd | input | 1 | Serial input, idles high |
| dsr_n | input | 1 | Active-low data-set-ready, reported inverted in status bit 7 |
| rxrdy | output | 1 | An unread character is waiting |

## Verification
The case where two functions fall in one clock is character completion at the stop-bit sample, meeting either a buffer read or an error-reset command. The bench first measures, from the ports, how many clocks pass from driving a start bit until `rxrdy` rises. It then replays a frame with a one-clock read or command strobe placed on the completing edge. The result is judged afterwards: the read must return the old byte and the status must show the new character with no overrun. In the command case, the parity flag of the completing bad character must survive the reset.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  // mode byte layout, MSB first
  typedef struct packed {
    logic [1:0] stop_sel;
    logic       par_even;
    logic       par_en;
    logic [1:0] len_sel;
    logic [1:0] rate_sel;
  } mode_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam int CMD_RX_ON  = 2;
  localparam int CMD_ERR_CL = 4;

  function automatic logic [3:0] char_bits(input logic [1:0] len_sel);
    return 4'd5 + {2'b00, len_sel};
  endfunction

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serrx_deframer.sv
module serrx_deframer
  import serrx_pkg::*;
#(
  parameter int BIT_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       line,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_even,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       perr,
  output logic       ferr
);
  localparam int CW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] MID  = CW'(BIT_CYCLES / 2 - 1);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [7:0]    shreg;
  logic          line_d;
  logic          par_bit;
  logic [3:0]    nbits;
  logic          tick;
  logic          ones;

  assign nbits = char_bits(len_sel);
  assign tick  = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      line_d  <= 1'b1;
      par_bit <= 1'b0;
    end else begin
      line_d <= line;
      if (!en) begin
        state <= RX_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          RX_IDLE: begin
            if (line_d && !line) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt   <= '0;
              idx   <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (tick) begin
              cnt   <= '0;
              shreg <= {line, shreg[7:1]};
              idx   <= idx + 4'd1;
              if (idx == nbits - 4'd1) state <= par_en ? RX_PAR : RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (tick) begin
              cnt     <= '0;
              par_bit <= line;
              state   <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy    = (state == RX_DATA) || (state == RX_PAR) || (state == RX_STOP);
  assign done    = en && (state == RX_STOP) && tick;
  assign rx_byte = shreg >> (4'd8 - nbits);
  assign ones    = ^rx_byte;
  assign perr    = par_en && ((ones ^ par_bit) == par_even);
  assign ferr    = !line;
endmodule

// File: rtl/serrx_regs.sv
module serrx_regs
  import serrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       cd,
  input  logic [7:0] din,
  input  logic       dsr_n,
  input  logic       busy,
  input  logic       done,
  input  logic [7:0] rx_byte,
  input  logic       perr,
  input  logic       ferr,
  output logic [7:0] dout,
  output logic       rxrdy,
  output logic [1:0] len_sel,
  output logic       par_en,
  output logic       par_even,
  output logic       rx_en,
  output logic       err_clr,
  output logic [7:0] status
);
  mode_t      mwr;
  logic       wr_ctl, rd_dat, rd_st;
  logic       mode_set;
  logic       unread;
  logic       pe_f, oe_f, fe_f;
  logic [7:0] rbuf;
  logic       unused_fields;

  assign mwr           = mode_t'(din);
  assign unused_fields = ^{mwr.stop_sel, mwr.rate_sel};

  assign wr_ctl  = !cs_n && !wr_n && cd;
  assign rd_dat  = !cs_n && !rd_n && !cd;
  assign rd_st   = !cs_n && !rd_n && cd;
  assign err_clr = wr_ctl && mode_set && din[CMD_ERR_CL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_set <= 1'b0;
      len_sel  <= 2'b00;
      par_en   <= 1'b0;
      par_even <= 1'b0;
      rx_en    <= 1'b0;
      unread   <= 1'b0;
      pe_f     <= 1'b0;
      oe_f     <= 1'b0;
      fe_f     <= 1'b0;
      rbuf     <= '0;
    end else begin
      if (wr_ctl) begin
        if (!mode_set) begin
          mode_set <= 1'b1;
          len_sel  <= mwr.len_sel;
          par_en   <= mwr.par_en;
          par_even <= mwr.par_even;
        end else begin
          rx_en <= din[CMD_RX_ON];
        end
      end
      if (err_clr) begin
        pe_f <= 1'b0;
        oe_f <= 1'b0;
        fe_f <= 1'b0;
      end
      if (rd_dat) unread <= 1'b0;
      // completion takes priority over a same-cycle read or clear
      if (done) begin
        rbuf   <= rx_byte;
        unread <= 1'b1;
        if (perr) pe_f <= 1'b1;
        if (ferr) fe_f <= 1'b1;
        if (unread && !rd_dat) oe_f <= 1'b1;
      end
    end
  end

  assign rxrdy  = rx_en && unread && !busy;
  assign status = {!dsr_n, 1'b0, fe_f, oe_f, pe_f, 1'b0, rxrdy, 1'b0};
  assign dout   = rd_dat ? rbuf : (rd_st ? status : 8'h00);
endmodule

// File: rtl/serrx_port.sv
module serrx_port #(
  parameter int BIT_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       cd,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic       rxd,
  input  logic       dsr_n,
  output logic       rxrdy
);
  logic       line_s;
  logic       rx_busy, rx_done, rx_perr, rx_ferr;
  logic [7:0] rx_byte;
  logic [1:0] len_sel;
  logic       par_en, par_even, rx_en, err_clr;
  logic [7:0] status;

  serrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
  );

  serrx_deframer #(.BIT_CYCLES(BIT_CYCLES)) u_deframe (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .line(line_s),
    .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
    .busy(rx_busy), .done(rx_done), .rx_byte(rx_byte),
    .perr(rx_perr), .ferr(rx_ferr)
  );

  serrx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cd(cd), .din(din), .dsr_n(dsr_n), .busy(rx_busy), .done(rx_done),
    .rx_byte(rx_byte), .perr(rx_perr), .ferr(rx_ferr), .dout(dout),
    .rxrdy(rxrdy), .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
    .rx_en(rx_en), .err_clr(err_clr), .status(status)
  );
endmodule

// File: rtl/serrx_port_chk.sv
module serrx_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       cd,
  input logic       rxrdy,
  input logic       busy,
  input logic       done,
  input logic       perr,
  input logic       ferr,
  input logic       rx_en,
  input logic       err_clr,
  input logic [7:0] status
);
  logic data_rd;
  assign data_rd = !cs_n && !rd_n && !cd;

  p_rxrdy_low_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rxrdy);

  p_quiet_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rxrdy);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !done) |=> !rxrdy);

  p_done_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (rxrdy || !rx_en));

  p_pe_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !err_clr) |=> status[3]);

  p_fe_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> $past(done && ferr));

  p_oe_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(done));

  p_pe_beats_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (done && perr && err_clr) |=> status[3]);
endmodule

bind serrx_port serrx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .cd(cd),
  .rxrdy(rxrdy), .busy(rx_busy), .done(rx_done), .perr(rx_perr),
  .ferr(rx_ferr), .rx_en(rx_en), .err_clr(err_clr), .status(status)
);

// File: tb/serrx_port_tb.sv
module serrx_port_tb;
  localparam int BC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       rxd = 1'b1;
  logic       dsr_n = 1'b0;
  logic       rxrdy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int c0 = 0;
  int lat = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  serrx_port #(.BIT_CYCLES(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cd(cd), .din(din), .dout(dout), .rxd(rxd), .dsr_n(dsr_n), .rxrdy(rxrdy)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired (all requirements) got timeout exp completion");
    report();
    $finish;
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a falling clock edge
  task automatic bus_wr(input logic c, input logic [7:0] v);
    cs_n = 0; wr_n = 0; cd = c; din = v;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic bus_rd(input logic c, output logic [7:0] v);
    cs_n = 0; rd_n = 0; cd = c;
    #5 v = dout;
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic hold_line(input logic lvl, input int n);
    rxd = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                            input bit even, input bit flip, input bit stop_lvl);
    logic par;
    par = 1'b0;
    for (int i = 0; i < nb; i++) par = par ^ d[i];
    if (!even) par = ~par;
    if (flip) par = ~par;
    hold_line(1'b0, BC);
    for (int i = 0; i < nb; i++) hold_line(d[i], BC);
    if (pen) hold_line(par, BC);
    hold_line(stop_lvl, BC);
    hold_line(1'b1, 2 * BC);
  endtask

  task automatic do_reset(input logic [7:0] mode);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    bus_wr(1, mode);
    bus_wr(1, 8'h14);
  endtask

  task automatic t_init();
    logic [7:0] v;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rxrdy after reset", {7'd0, rxrdy}, 8'h00);
    bus_wr(1, 8'hFD);
    bus_wr(1, 8'h14);
    bus_rd(1, v); chk("R1 status after init", v, 8'h80);
    dsr_n = 1;
    bus_rd(1, v); chk("R1 status dsr_n high", v, 8'h00);
    dsr_n = 0;
  endtask

  task automatic t_good();
    logic [7:0] v;
    c0 = cyc;
    fork
      send_frame(8'h55, 8, 1, 1, 0, 1);
      begin
        repeat (2 * BC) @(negedge clk);
        while (!rxrdy && cyc < c0 + 20 * BC) @(negedge clk);
        lat = cyc - c0;
      end
    join
    bus_rd(1, v); chk("R3 status good char", v, 8'h82);
    bus_rd(0, v); chk("R3 data good char", v, 8'h55);
    bus_rd(1, v); chk("R7 status after read", v, 8'h80);
    chk("R7 rxrdy after read", {7'd0, rxrdy}, 8'h00);
    bus_rd(0, v); chk("R7 data re-read", v, 8'h55);
  endtask

  task automatic t_parity();
    logic [7:0] v;
    send_frame(8'h5A, 8, 1, 1, 1, 1);
    bus_rd(1, v); chk("R5 status parity error", v, 8'h8A);
    bus_rd(0, v); chk("R5 data kept", v, 8'h5A);
    bus_wr(1, 8'h14);
    bus_rd(1, v); chk("R2 error reset", v, 8'h80);
  endtask

  task automatic t_framing();
    logic [7:0] v;
    send_frame(8'h57, 8, 1, 1, 0, 0);
    bus_rd(1, v); chk("R6 status framing error", v, 8'hA2);
    bus_rd(0, v); chk("R6 data kept", v, 8'h57);
    bus_wr(1, 8'h14);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    send_frame(8'h11, 8, 1, 1, 1, 1);
    bus_rd(0, v);
    send_frame(8'h22, 8, 1, 1, 0, 1);
    bus_rd(1, v); chk("R9 parity flag held", v, 8'h8A);
    bus_rd(0, v); chk("R9 later data", v, 8'h22);
    bus_wr(1, 8'h14);
    bus_rd(1, v); chk("R9 cleared by command", v, 8'h80);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    send_frame(8'h33, 8, 1, 1, 0, 1);
    chk("R8 first char ready", {7'd0, rxrdy}, 8'h01);
    fork
      send_frame(8'h44, 8, 1, 1, 0, 1);
      begin
        repeat (3 * BC) @(negedge clk);
        chk("R4 rxrdy low mid-frame", {7'd0, rxrdy}, 8'h00);
      end
    join
    bus_rd(1, v); chk("R8 status overrun", v, 8'h92);
    bus_rd(0, v); chk("R8 data overwritten", v, 8'h44);
    bus_wr(1, 8'h14);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    hold_line(1'b0, 2);
    hold_line(1'b1, 12 * BC);
    chk("R10 rxrdy after glitch", {7'd0, rxrdy}, 8'h00);
    bus_rd(1, v); chk("R10 status after glitch", v, 8'h80);
    send_frame(8'h66, 8, 1, 1, 0, 1);
    bus_rd(0, v); chk("R10 frame after glitch", v, 8'h66);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    bus_wr(1, 8'h10);
    send_frame(8'h77, 8, 1, 1, 0, 1);
    chk("R11 rxrdy while disabled", {7'd0, rxrdy}, 8'h00);
    bus_wr(1, 8'h14);
    bus_rd(1, v); chk("R11 nothing received", v, 8'h80);
  endtask

  task automatic t_lengths();
    logic [7:0] v;
    do_reset(8'h51);               // 5 bits, odd parity
    send_frame(8'h15, 5, 1, 0, 0, 1);
    bus_rd(1, v); chk("R12 5-bit odd status", v, 8'h82);
    bus_rd(0, v); chk("R12 5-bit data", v, 8'h15);
    send_frame(8'h0C, 5, 1, 0, 1, 1);
    bus_rd(1, v); chk("R12 odd parity error", v, 8'h8A);
    do_reset(8'h49);               // 7 bits, no parity
    send_frame(8'h5B, 7, 0, 0, 0, 1);
    bus_rd(0, v); chk("R12 7-bit data", v, 8'h5B);
  endtask

  task automatic t_concurrent();
    logic [7:0] v;
    do_reset(8'hFD);
    send_frame(8'h12, 8, 1, 1, 0, 1);
    c0 = cyc;
    fork
      send_frame(8'h34, 8, 1, 1, 0, 1);
      begin
        while (cyc != c0 + lat - 1) @(negedge clk);
        bus_rd(0, v);
        chk("R13 read at completion old byte", v, 8'h12);
      end
    join
    bus_rd(1, v); chk("R13 ready, no overrun", v, 8'h82);
    bus_rd(0, v); chk("R13 new byte", v, 8'h34);
    c0 = cyc;
    fork
      send_frame(8'h56, 8, 1, 1, 1, 1);
      begin
        while (cyc != c0 + lat - 1) @(negedge clk);
        bus_wr(1, 8'h14);
      end
    join
    bus_rd(1, v); chk("R13 parity survives clear", v, 8'h8A);
  endtask

  initial begin
    t_init();
    t_good();
    t_parity();
    t_framing();
    t_sticky();
    t_overrun();
    t_glitch();
    t_disabled();
    t_lengths();
    t_concurrent();
    report();
    $finish;
  end
endmodule